// File: doc/BRIEF.md
# Coded Comparison-Rate Divider

This block turns the reference clock of a frequency synthesizer into the much slower rate at which the phase comparator works. A 4-bit select code picks the division ratio from two ratio families. The first nine codes form a power-of-two ladder from 2 to 512. The remaining seven codes form a ladder of three times a power of two, from 6 to 384. This lets a reference in the 3 to 20 MHz range reach comparison rates from several MHz down to a few tens of kHz.

The block drives two outputs. One is a strobe one reference cycle wide that marks the start of every comparison period. The other is a square wave at the comparison rate. Every legal ratio is even, so the square wave always has an exact 50% duty cycle.

The select code may change at any time. The block applies a new code only at a period boundary, so no period is ever cut short or stretched.

Top module: `cmp_rate_divider`

## Requirements
- R1: Select codes 0 to 8 (binary value c, bit 3 as MSB) give a division ratio of 2 raised to the power (c+1), i.e. 2, 4, 8 up to 512.
- R2: Select codes 9 to 15 give a ratio of 6 times 2 raised to the power (c-9), i.e. 6, 12, 24 up to 384.
- R3: While reset is asserted (rst_n low), both outputs are low and the active ratio is 2. With code 0 applied, the first strobe is high after the second rising clock edge following reset release, and not after the first.
- R4: cmp_pulse is high for exactly one reference cycle. It repeats every N cycles, where N is the active ratio.
- R5: div_clk is high for N/2 cycles and then low for N/2 cycles. It rises in the same cycle that cmp_pulse is high, and it is low in the last cycle of every period.
- R6: A code change made in the middle of a period does not alter the length of that period. A code that is changed and then restored before the period ends has no effect at all.
- R7: The code present during the last cycle of a period sets the ratio of the next period. The code is sampled on the clock edge that ends the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ratio_code | input | 4 | Division ratio select code |
| cmp_pulse | output | 1 | One-cycle strobe at the start of each comparison period |
| div_clk | output | 1 | 50% duty clock at the comparison rate |

## Verification
The bench builds the block with its default 4-bit code and 10-bit counter, which cover the whole ratio table, from 2 up to 512. At these sizes the bench can sweep all sixteen codes. For each code it measures the strobe spacing and the high time of the square wave across full periods. Further directed sequences change the code in the middle of a period, in the final cycle of a period, and back and forth within one period. These show whether the boundary sampling rule holds.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
  localparam int CODE_W     = 4;
  localparam int POW2_CODES = 9;
  localparam int RATIO_W    = 10;

  typedef logic [CODE_W-1:0]  code_t;
  typedef logic [RATIO_W-1:0] ratio_t;

  // Power-of-two ladder for low codes, three-times ladder above it.
  function automatic ratio_t code_to_ratio(input code_t c);
    ratio_t r;
    if (int'(c) < POW2_CODES) r = ratio_t'(2) << c;
    else                      r = ratio_t'(6) << (c - code_t'(POW2_CODES));
    return r;
  endfunction

  function automatic ratio_t half_of(input ratio_t r);
    return r >> 1;
  endfunction
endpackage

// File: rtl/refdiv_decode.sv
module refdiv_decode
  import refdiv_pkg::*;
(
  input  code_t  code,
  output ratio_t ratio
);
  always_comb ratio = code_to_ratio(code);
endmodule

// File: rtl/refdiv_counter.sv
module refdiv_counter
  import refdiv_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  ratio_t next_ratio,
  output ratio_t cnt,
  output ratio_t act_ratio,
  output logic   wrap_evt,
  output logic   half_evt
);
  localparam code_t RESET_CODE = '0;

  always_comb begin
    wrap_evt = (cnt == act_ratio - ratio_t'(1));
    half_evt = (cnt == half_of(act_ratio) - ratio_t'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      act_ratio <= code_to_ratio(RESET_CODE);
    end else if (wrap_evt) begin
      cnt       <= '0;
      act_ratio <= next_ratio;
    end else begin
      cnt       <= cnt + ratio_t'(1);
    end
  end
endmodule

// File: rtl/refdiv_outgen.sv
module refdiv_outgen (
  input  logic clk,
  input  logic rst_n,
  input  logic wrap_evt,
  input  logic half_evt,
  output logic cmp_pulse,
  output logic div_clk
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_pulse <= 1'b0;
      div_clk   <= 1'b0;
    end else begin
      cmp_pulse <= wrap_evt;
      if (wrap_evt)      div_clk <= 1'b1;
      else if (half_evt) div_clk <= 1'b0;
    end
  end
endmodule

// File: rtl/cmp_rate_divider.sv
module cmp_rate_divider
  import refdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] ratio_code,
  output logic              cmp_pulse,
  output logic              div_clk
);
  ratio_t next_ratio;
  ratio_t cnt;
  ratio_t act_ratio;
  logic   wrap_evt;
  logic   half_evt;

  refdiv_decode u_dec (
    .code  (ratio_code),
    .ratio (next_ratio)
  );

  refdiv_counter u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .next_ratio (next_ratio),
    .cnt        (cnt),
    .act_ratio  (act_ratio),
    .wrap_evt   (wrap_evt),
    .half_evt   (half_evt)
  );

  refdiv_outgen u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .wrap_evt  (wrap_evt),
    .half_evt  (half_evt),
    .cmp_pulse (cmp_pulse),
    .div_clk   (div_clk)
  );
endmodule

// File: rtl/refdiv_checker.sv
module refdiv_checker
  import refdiv_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input code_t  ratio_code,
  input logic   cmp_pulse,
  input logic   div_clk,
  input logic   wrap_evt,
  input ratio_t cnt,
  input ratio_t act_ratio
);
  assert_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_pulse |=> !cmp_pulse);

  assert_count_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < act_ratio);

  assert_pulse_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_pulse |-> div_clk);

  assert_low_at_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |-> !div_clk);

  assert_ratio_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_evt |=> $stable(act_ratio));

  assert_ratio_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (act_ratio == code_to_ratio($past(ratio_code))));

  assert_ratio_family_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(act_ratio) == 1) || ($countones(act_ratio) == 2));
endmodule

bind cmp_rate_divider refdiv_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ratio_code (ratio_code),
  .cmp_pulse  (cmp_pulse),
  .div_clk    (div_clk),
  .wrap_evt   (wrap_evt),
  .cnt        (cnt),
  .act_ratio  (act_ratio)
);

// File: tb/sim_cmp_rate_divider.sv
module sim_cmp_rate_divider;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] ratio_code = 4'd0;
  logic       cmp_pulse;
  logic       div_clk;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit done    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_rate_divider u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .ratio_code (ratio_code),
    .cmp_pulse  (cmp_pulse),
    .div_clk    (div_clk)
  );

  // Independent restatement: ratio = 2^(c+1) below 9, else 3 * 2^(c-8).
  function automatic int exp_ratio(input int c);
    if (c <= 8) return 2 ** (c + 1);
    return 3 * (2 ** (c - 8));
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic wait_pulse();
    do @(negedge clk); while (!cmp_pulse);
  endtask

  // Starting at a pulse sample: measure period length and high time.
  task automatic measure(output int len, output int hi);
    len = 1;
    hi  = div_clk ? 1 : 0;
    forever begin
      @(negedge clk);
      if (cmp_pulse) break;
      len++;
      if (div_clk) hi++;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    int len, hi;
    // R3: reset state
    repeat (3) @(negedge clk);
    chk(!cmp_pulse && !div_clk, "R3 outputs low in reset", {cmp_pulse, div_clk}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!cmp_pulse, "R3 no pulse after first edge", cmp_pulse, 0);
    @(negedge clk);
    chk(cmp_pulse, "R3 pulse after second edge", cmp_pulse, 1);
    measure(len, hi);
    chk(len == 2, "R3 reset ratio is 2", len, 2);

    // R1 R2 R4 R5: sweep every code; set just after a pulse sample (R7 path).
    for (int c = 0; c < 16; c++) begin
      ratio_code = 4'(c);
      wait_pulse();
      chk(div_clk == 1'b1, "R5 div_clk high with pulse", div_clk, 1);
      measure(len, hi);
      if (c <= 8) chk(len == exp_ratio(c), $sformatf("R1 period code %0d", c), len, exp_ratio(c));
      else        chk(len == exp_ratio(c), $sformatf("R2 period code %0d", c), len, exp_ratio(c));
      chk(hi == exp_ratio(c) / 2, $sformatf("R5 high time code %0d", c), hi, exp_ratio(c) / 2);
      measure(len, hi);
      chk(len == exp_ratio(c), $sformatf("R4 repeat period code %0d", c), len, exp_ratio(c));
    end

    // R6: mid-period change keeps the running period at 32.
    ratio_code = 4'd4;
    wait_pulse();
    measure(len, hi);
    len = 1;
    forever begin
      @(negedge clk);
      if (cmp_pulse) break;
      len++;
      if (len == 5) ratio_code = 4'd9;
    end
    chk(len == 32, "R6 running period unchanged", len, 32);
    measure(len, hi);
    chk(len == 6, "R6 new ratio next period", len, 6);

    // R6: change and restore within one period has no effect.
    len = 1;
    forever begin
      @(negedge clk);
      if (cmp_pulse) break;
      len++;
      if (len == 2) ratio_code = 4'd15;
      if (len == 4) ratio_code = 4'd9;
    end
    chk(len == 6, "R6 toggled code period", len, 6);
    measure(len, hi);
    chk(len == 6, "R6 toggled code ignored", len, 6);

    // R7: code set in the last cycle of a period decides the next one.
    len = 1;
    forever begin
      @(negedge clk);
      if (cmp_pulse) break;
      len++;
      if (len == 6) ratio_code = 4'd0;
    end
    chk(len == 6, "R7 period before late change", len, 6);
    measure(len, hi);
    chk(len == 2, "R7 late change applied", len, 2);
    chk(hi == 1, "R5 high time ratio 2", hi, 1);

    finish_run();
  end
endmodule